// File: doc/BRIEF.md
# SAR Conversion Timing Engine

This block sequences a single successive-approximation conversion. A start strobe opens an acquisition window whose length is set in whole clock cycles. A compare phase follows, in which a trial code is presented to an external comparator and the answer is resolved one bit at a time, most significant bit first. Each bit is held for a programmable number of clock cycles before the comparator is read. The engine resolves either ten or eight bits. It writes the outcome, zero-extended, into a 16-bit result word and marks completion with a one-cycle pulse.

The sample-and-hold, the capacitor DAC and the comparator are not part of this block. The engine only drives the trial code and reads back one comparator bit: high means the held input is at or above the trial level. The timing and resolution settings are copied when a conversion is accepted, so the source of those settings may change them freely while a conversion runs. After reset the copy holds a compare setting of 4 and a sample setting of 44.

Top module: `sar_conv_engine`

## Requirements
- R1: After a synchronous reset, `busy_o`, `sampling_o`, `done_o` and `cfg_err_o` are low, and `result_o` and `trial_code_o` are zero.
- R2: A start accepted in idle raises `sampling_o` from the next cycle for exactly `samp_cycles_i` cycles. A setting of 0 skips the sample phase.
- R3: The compare phase lasts exactly N × `cmp_cycles_i` cycles, where N is the number of result bits. `busy_o` is therefore high for samp + N × cmp cycles. `done_o` is high for one cycle, in the cycle right after `busy_o` falls.
- R4: Bits are resolved MSB first. Each trial sets the current bit on top of the bits already kept. The bit is kept if `cmp_ge_i` is 1 in the last cycle of its period, and cleared otherwise. With an ideal comparator the result equals the input code. `trial_code_o` is zero whenever the block is not busy.
- R5: A start with `cmp_cycles_i` equal to 0 is refused. `cfg_err_o` is high for one cycle in the next cycle, `busy_o` stays low, and `result_o` is not changed.
- R6: `res8_i` = 0 selects 10 bits (first trial 0x200). `res8_i` = 1 selects 8 bits (first trial 0x080), and in that mode bits 9..8 of both the trial code and the result stay 0.
- R7: Bits 15..10 of `result_o` are always 0. The data sits right-aligned from bit 0.
- R8: `result_o` changes only in the cycle where `done_o` is high, and holds its value otherwise.
- R9: `abort_i` in either phase returns the block to idle in the next cycle. That conversion gives no `done_o` and no change to `result_o`. An abort in idle makes a start in the same cycle ignored.
- R10: A start while busy is ignored. The settings are captured when a start is accepted, so changes to the setting inputs during a conversion affect neither its timing nor its resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted in idle |
| abort_i | input | 1 | Abandon the conversion in progress |
| samp_cycles_i | input | 10 | Sample phase length in clock cycles |
| cmp_cycles_i | input | 6 | Clock cycles per resolved bit; 0 is illegal |
| res8_i | input | 1 | 0 = 10-bit, 1 = 8-bit conversion |
| cmp_ge_i | input | 1 | Comparator: held input at or above trial level |
| trial_code_o | output | 10 | Trial code presented to the DAC |
| sampling_o | output | 1 | Sample phase active |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a result is written |
| cfg_err_o | output | 1 | One-cycle pulse after a refused start |
| result_o | output | 16 | Last completed result, zero-extended |

## Verification
The bench goes after the edges of the timing counters. It uses a sample setting of 0, which must skip the sample phase rather than wrap to 1023 cycles, and a compare setting of 1. An off-by-one counter shows up as a busy length that differs from samp + N × cmp. It also uses the input extremes 0 and full scale in both resolutions. A comparator read in the wrong cycle, or a bit cleared in the wrong order, gives a wrong code there. An 8-bit run that starts from the 10-bit MSB leaks into bits 9..8. The bench covers aborts in each phase, where a faulty design would still pulse done or overwrite the result. It covers setting changes and a second start during a busy conversion, where a design that does not capture its settings would stretch, shorten or resize the run. It also covers the all-zero compare setting, which a faulty design would accept and then hang on or run with a wrapped count.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    localparam int SAMP_W   = 10;
    localparam int CMP_W    = 6;
    localparam int CODE_W   = 10;
    localparam int NARROW_W = 8;
    localparam int RES_W    = 16;
    localparam int TMR_W    = (SAMP_W > CMP_W) ? SAMP_W : CMP_W;

    localparam logic [SAMP_W-1:0] SAMP_DEFAULT = SAMP_W'(44);
    localparam logic [CMP_W-1:0]  CMP_DEFAULT  = CMP_W'(4);

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_COMPARE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SAMP_W-1:0] samp;
        logic [CMP_W-1:0]  cmp;
        logic              narrow;
    } timing_cfg_t;

    // One-hot trial bit for the most significant resolved bit
    function automatic logic [CODE_W-1:0] first_trial(input logic narrow);
        logic [CODE_W-1:0] one;
        one = CODE_W'(1);
        return narrow ? (one << (NARROW_W - 1)) : (one << (CODE_W - 1));
    endfunction

    // Zero-extend a resolved code into the result word
    function automatic logic [RES_W-1:0] pad_result(input logic [CODE_W-1:0] code,
                                                    input logic narrow);
        logic [CODE_W-1:0] keep_mask;
        keep_mask = narrow ? CODE_W'((1 << NARROW_W) - 1) : {CODE_W{1'b1}};
        return RES_W'(code & keep_mask);
    endfunction

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic         at_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (dec_en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_resolver.sv
module sar_bit_resolver #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_en,
    input  logic [W-1:0] init_onehot,
    input  logic         decide_en,
    input  logic         keep_bit,
    input  logic         clear_en,
    output logic [W-1:0] trial_code,
    output logic [W-1:0] resolved_code,
    output logic         on_last_bit
);
    logic [W-1:0] code_q;
    logic [W-1:0] ptr_q;
    logic [W-1:0] ptr_next;

    // Current bit settled by the comparator answer
    assign resolved_code = keep_bit ? code_q : (code_q & ~ptr_q);
    assign ptr_next      = ptr_q >> 1;
    assign on_last_bit   = ptr_q[0];
    assign trial_code    = code_q;

    always_ff @(posedge clk) begin
        if (rst || clear_en) begin
            code_q <= '0;
            ptr_q  <= '0;
        end else if (init_en) begin
            code_q <= init_onehot;
            ptr_q  <= init_onehot;
        end else if (decide_en) begin
            if (on_last_bit) begin
                code_q <= '0;
                ptr_q  <= '0;
            end else begin
                code_q <= resolved_code | ptr_next;
                ptr_q  <= ptr_next;
            end
        end
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_conv_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  timing_cfg_t   cfg_in,
    input  logic          tmr_zero,
    input  logic          last_bit,
    output phase_e        phase,
    output timing_cfg_t   cfg_live,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          tmr_dec,
    output logic          bit_init,
    output logic          bit_decide,
    output logic          bit_clear,
    output logic          finish,
    output logic          cfg_err
);
    phase_e      phase_q, phase_d;
    timing_cfg_t cfg_q, cfg_d;
    logic        err_q, err_d;

    always_comb begin
        phase_d    = phase_q;
        cfg_d      = cfg_q;
        err_d      = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tmr_dec    = 1'b0;
        bit_init   = 1'b0;
        bit_decide = 1'b0;
        bit_clear  = 1'b0;
        finish     = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start && !abort) begin
                    if (cfg_in.cmp == '0) begin
                        err_d = 1'b1;
                    end else begin
                        cfg_d    = cfg_in;
                        tmr_load = 1'b1;
                        if (cfg_in.samp != '0) begin
                            phase_d = PH_SAMPLE;
                            tmr_val = TW'(cfg_in.samp) - TW'(1);
                        end else begin
                            phase_d  = PH_COMPARE;
                            bit_init = 1'b1;
                            tmr_val  = TW'(cfg_in.cmp) - TW'(1);
                        end
                    end
                end
            end
            PH_SAMPLE: begin
                if (abort) begin
                    phase_d   = PH_IDLE;
                    bit_clear = 1'b1;
                end else if (tmr_zero) begin
                    phase_d  = PH_COMPARE;
                    bit_init = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(cfg_q.cmp) - TW'(1);
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            PH_COMPARE: begin
                if (abort) begin
                    phase_d   = PH_IDLE;
                    bit_clear = 1'b1;
                end else if (tmr_zero) begin
                    bit_decide = 1'b1;
                    if (last_bit) begin
                        finish  = 1'b1;
                        phase_d = PH_IDLE;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(cfg_q.cmp) - TW'(1);
                    end
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: begin
                phase_d   = PH_IDLE;
                bit_clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '{samp: SAMP_DEFAULT, cmp: CMP_DEFAULT, narrow: 1'b0};
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cfg_q   <= cfg_d;
            err_q   <= err_d;
        end
    end

    assign phase    = phase_q;
    assign cfg_live = cfg_q;
    assign cfg_err  = err_q;
endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine
    import sar_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [SAMP_W-1:0] samp_cycles_i,
    input  logic [CMP_W-1:0]  cmp_cycles_i,
    input  logic              res8_i,
    input  logic              cmp_ge_i,
    output logic [CODE_W-1:0] trial_code_o,
    output logic              sampling_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cfg_err_o,
    output logic [RES_W-1:0]  result_o
);
    phase_e            phase;
    timing_cfg_t       cfg_in, cfg_live;
    logic              tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              bit_init, bit_decide, bit_clear, last_bit, finish;
    logic [CODE_W-1:0] resolved;
    logic [RES_W-1:0]  result_q;
    logic              done_q;

    assign cfg_in = '{samp: samp_cycles_i, cmp: cmp_cycles_i, narrow: res8_i};

    sar_seq_ctrl #(.TW(TMR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .abort      (abort_i),
        .cfg_in     (cfg_in),
        .tmr_zero   (tmr_zero),
        .last_bit   (last_bit),
        .phase      (phase),
        .cfg_live   (cfg_live),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .tmr_dec    (tmr_dec),
        .bit_init   (bit_init),
        .bit_decide (bit_decide),
        .bit_clear  (bit_clear),
        .finish     (finish),
        .cfg_err    (cfg_err_o)
    );

    sar_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_en  (tmr_load),
        .load_val (tmr_val),
        .dec_en   (tmr_dec),
        .at_zero  (tmr_zero)
    );

    sar_bit_resolver #(.W(CODE_W)) u_bits (
        .clk           (clk),
        .rst           (rst),
        .init_en       (bit_init),
        .init_onehot   (first_trial(phase == PH_IDLE ? res8_i : cfg_live.narrow)),
        .decide_en     (bit_decide),
        .keep_bit      (cmp_ge_i),
        .clear_en      (bit_clear),
        .trial_code    (trial_code_o),
        .resolved_code (resolved),
        .on_last_bit   (last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                result_q <= pad_result(resolved, cfg_live.narrow);
            end
        end
    end

    assign result_o   = result_q;
    assign done_o     = done_q;
    assign busy_o     = (phase != PH_IDLE);
    assign sampling_o = (phase == PH_SAMPLE);
endmodule

// File: rtl/sar_conv_engine_chk.sv
module sar_conv_engine_chk
    import sar_conv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              abort_i,
    input logic [CODE_W-1:0] trial_code_o,
    input logic              sampling_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              cfg_err_o,
    input logic [RES_W-1:0]  result_o
);
    logic warm_q;

    always_ff @(posedge clk) begin
        warm_q <= !rst;
    end

    AST_RESULT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        result_o[RES_W-1:CODE_W] == '0); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R3

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst || !warm_q)
        done_o |-> ($past(busy_o) && !busy_o)); // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst || !warm_q)
        !done_o |-> $stable(result_o)); // R8

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!busy_o && !done_o)); // R9

    AST_REFUSED_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> !busy_o); // R5

    AST_SAMPLE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
        sampling_o |-> busy_o); // R2

    AST_IDLE_TRIAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (trial_code_o == '0)); // R4
endmodule

bind sar_conv_engine sar_conv_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .abort_i      (abort_i),
    .trial_code_o (trial_code_o),
    .sampling_o   (sampling_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cfg_err_o    (cfg_err_o),
    .result_o     (result_o)
);

// File: tb/sar_conv_engine_tb.sv
module sar_conv_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic [9:0]  samp_cycles_i = 10'd44;
    logic [5:0]  cmp_cycles_i = 6'd4;
    logic        res8_i = 1'b0;
    logic        cmp_ge_i;
    logic [9:0]  trial_code_o;
    logic        sampling_o, busy_o, done_o, cfg_err_o;
    logic [15:0] result_o;
    logic [9:0]  vin = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    // Ideal comparator model
    assign cmp_ge_i = (vin >= trial_code_o);

    sar_conv_engine u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
        .samp_cycles_i(samp_cycles_i), .cmp_cycles_i(cmp_cycles_i),
        .res8_i(res8_i), .cmp_ge_i(cmp_ge_i), .trial_code_o(trial_code_o),
        .sampling_o(sampling_o), .busy_o(busy_o), .done_o(done_o),
        .cfg_err_o(cfg_err_o), .result_o(result_o)
    );

    // Fields: res8[26] samp[25:16] cmp[15:10] vin[9:0]
    localparam logic [26:0] VECS [10] = '{
        {1'b0, 10'd44,   6'd4,  10'd613},
        {1'b0, 10'd1,    6'd1,  10'd0},
        {1'b0, 10'd0,    6'd1,  10'd1023},
        {1'b0, 10'd3,    6'd2,  10'd512},
        {1'b0, 10'd7,    6'd5,  10'd511},
        {1'b1, 10'd2,    6'd3,  10'd255},
        {1'b1, 10'd0,    6'd1,  10'd0},
        {1'b1, 10'd5,    6'd63, 10'd128},
        {1'b0, 10'd1023, 6'd1,  10'd1},
        {1'b1, 10'd12,   6'd2,  10'd170}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    // Runs one conversion; returns counts observed at negedges until done
    task automatic run_conv(input logic narrow, input logic [9:0] s, input logic [5:0] c,
                            input logic [9:0] v, output int scnt, output int bcnt,
                            output int tmax);
        int guard;
        @(negedge clk);
        res8_i = narrow; samp_cycles_i = s; cmp_cycles_i = c; vin = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        scnt = 0; bcnt = 0; tmax = 0; guard = 0;
        while (!done_o && guard < 5000) begin
            if (busy_o) bcnt++;
            if (sampling_o) scnt++;
            if (int'(trial_code_o) > tmax) tmax = int'(trial_code_o);
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        int sc, bc, tm;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // r1_ reset state
        chk(!busy_o && !sampling_o && !done_o && !cfg_err_o, "R1 flags", busy_o, 0);
        chk(result_o == 16'd0, "R1 result", result_o, 0);
        chk(trial_code_o == 10'd0, "R1 trial", trial_code_o, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            logic        n;
            logic [9:0]  s, v;
            logic [5:0]  c;
            int          nb;
            n = VECS[i][26]; s = VECS[i][25:16]; c = VECS[i][15:10]; v = VECS[i][9:0];
            nb = n ? 8 : 10;
            run_conv(n, s, c, v, sc, bc, tm);
            chk(done_o == 1'b1, "R3 done pulse", done_o, 1);
            chk(result_o == {6'd0, v}, "R4 result", result_o, v);
            chk(sc == int'(s), "R2 sample length", sc, s);
            chk(bc == int'(s) + nb * int'(c), "R3 busy length", bc, int'(s) + nb * int'(c));
            chk(result_o[15:10] == 6'd0, "R7 upper bits", result_o[15:10], 0);
            if (n) chk(tm < 256, "R6 narrow trial", tm, 255);
            else   chk(tm >= 512, "R6 wide first trial", tm, 512);
            @(negedge clk);
            chk(done_o == 1'b0, "R3 done single", done_o, 0);
        end

        // R8: result holds while idle and input changes
        held = result_o;
        vin = 10'd999;
        repeat (20) @(negedge clk);
        chk(result_o == held, "R8 hold idle", result_o, held);

        // R5: zero compare setting refused
        cmp_cycles_i = 6'd0; samp_cycles_i = 10'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cfg_err_o == 1'b1 && busy_o == 1'b0, "R5 refuse", cfg_err_o, 1);
        @(negedge clk);
        chk(cfg_err_o == 1'b0 && busy_o == 1'b0, "R5 pulse end", cfg_err_o, 0);
        chk(result_o == held, "R5 result kept", result_o, held);

        // R9: abort during sample phase
        samp_cycles_i = 10'd10; cmp_cycles_i = 6'd3; res8_i = 1'b0; vin = 10'd77;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(sampling_o == 1'b1, "R9 in sample", sampling_o, 1);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(busy_o == 1'b0 && trial_code_o == 10'd0, "R9 idle after sample abort", busy_o, 0);
        begin
            int dseen;
            dseen = 0;
            repeat (60) begin @(negedge clk); if (done_o) dseen++; end
            chk(dseen == 0, "R9 no done", dseen, 0);
        end
        chk(result_o == held, "R9 result kept", result_o, held);

        // R9: abort during compare phase
        samp_cycles_i = 10'd2; cmp_cycles_i = 6'd2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (7) @(negedge clk);
        chk(busy_o && !sampling_o, "R9 in compare", busy_o, 1);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(busy_o == 1'b0, "R9 idle after compare abort", busy_o, 0);
        begin
            int dseen;
            dseen = 0;
            repeat (40) begin @(negedge clk); if (done_o) dseen++; end
            chk(dseen == 0, "R9 no done compare", dseen, 0);
        end
        chk(result_o == held, "R9 result kept compare", result_o, held);

        // R9: abort in idle suppresses a simultaneous start
        start_i = 1'b1; abort_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        chk(busy_o == 1'b0, "R9 abort blocks start", busy_o, 0);

        // R10: settings captured; restart ignored while busy
        @(negedge clk);
        samp_cycles_i = 10'd5; cmp_cycles_i = 6'd2; res8_i = 1'b0; vin = 10'd300;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        begin
            int bcnt, g;
            bcnt = 0; g = 0;
            while (!done_o && g < 5000) begin
                if (busy_o) bcnt++;
                if (g == 3) begin
                    samp_cycles_i = 10'd20; cmp_cycles_i = 6'd7; res8_i = 1'b1;
                    start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                g++;
                @(negedge clk);
            end
            start_i = 1'b0;
            chk(bcnt == 25, "R10 timing kept", bcnt, 25);
            chk(result_o == 16'd300, "R10 width kept", result_o, 300);
        end
        @(negedge clk);
        chk(busy_o == 1'b0, "R10 no restart", busy_o, 0);

        summary();
        $finish;
    end
endmodule